// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Microcontroller Core

A small processor that runs programs held in a single synchronous memory. It uses one port for both code and data, and that port has a read latency of one cycle. Every instruction is one 16-bit word. The top four bits are the opcode, bits 11:8 name the destination or test register (called Rn below), and the low byte is a direct address, an immediate value or a signed jump offset. For the two-register forms, bits 7:4 name the second register (called Rm below). The datapath has a register file of sixteen 16-bit entries, one ALU with a zero flag, a program counter and an instruction register.

A controller state machine steps through each instruction:

- `S_RESET` clears the PC and moves to `S_FETCH`.
- `S_FETCH` drives the PC onto the memory port with a read.
- `S_FWAIT` captures the returned word into the instruction register, increments the PC, and moves to `S_DECODE`.
- `S_DECODE` branches on the opcode to one execute state:
  - `S_LDD`, then `S_LDD_WAIT`
  - `S_STD`
  - `S_STI`
  - `S_LDI`
  - `S_ADD`
  - `S_SUB`
  - `S_JZ`
  - `S_OUT`, then `S_OUT_WAIT`
  - `S_NOP`
- Every execute state returns to `S_FETCH`.

The output instruction reads one memory word and presents it on a data port with a strobe that lasts one cycle. Systems use the core as a tiny sequencer: they preload the memory and watch the output port.

Top module: `tiny_mcu_core`

## Requirements
- R1: While reset is asserted, the core drives no read, no write and no output strobe. After reset is released, the first read issued fetches address 0.
- R2: A fetch issues a read at the PC. The word returned one cycle later becomes the instruction, and the PC advances by one. Read enable and write enable are never high together.
- R3: Opcode 0 loads Rn from the memory word whose address is the low byte.
- R4: Opcode 1 writes Rn to the memory word whose address is the low byte.
- R5: Opcode 2 writes Rm to the memory word whose address is held in Rn.
- R6: Opcode 3 loads Rn with the low byte zero-extended to 16 bits.
- R7: Opcode 4 sets Rn to Rn+Rm and opcode 5 sets Rn to Rn−Rm, both modulo 2^16.
- R8: Opcode 6 adds the low byte, taken as a signed 8-bit value, to the already-incremented PC, but only when Rn is zero. Otherwise execution continues with the next word.
- R9: Opcode 7 reads the memory word whose address is the low byte and presents it on `out_data` with `out_valid` high for exactly one cycle.
- R10: Opcodes 8 to 15 change no register, no memory word and no output. Execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address for memory read or write |
| mem_wdata | output | 16 | Data for a memory write |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| mem_re | output | 1 | Read enable |
| mem_we | output | 1 | Write enable |
| out_data | output | 16 | Value presented by the output instruction |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |

## Verification
The first pattern is a looping Fibonacci program. It uses the indirect store, the not-taken and taken jump, the register moves built from add, and the output opcode. Ten correct memory words and ten ordered strobes show that the jump offset is applied to the incremented PC, and that the decrement-then-test exit leaves the loop exactly once.

A directed tail adds several cases:
- a direct load and a direct store, which separate them from the indirect store;
- a subtraction that wraps below zero, which shows 16-bit modulo behaviour;
- an immediate of 0xFF, which tells zero extension from sign extension;
- a no-op opcode whose fields look like a store, which would show a stray write or strobe.

A second program runs fixed-seed random byte pairs together with the corners (0,0), (255,255) and (0,255). It compares both sums and differences against values the bench computes itself.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    typedef enum logic [3:0] {
        OP_LDD = 4'd0,
        OP_STD = 4'd1,
        OP_STI = 4'd2,
        OP_LDI = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_JZ  = 4'd6,
        OP_OUT = 4'd7
    } opc_t;

    typedef enum logic [3:0] {
        S_RESET,
        S_FETCH,
        S_FWAIT,
        S_DECODE,
        S_LDD,
        S_LDD_WAIT,
        S_STD,
        S_STI,
        S_LDI,
        S_ADD,
        S_SUB,
        S_JZ,
        S_OUT,
        S_OUT_WAIT,
        S_NOP
    } ctl_state_t;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_PASS
    } alu_op_t;

    localparam int unsigned REG_SEL_W = 4;
    localparam int unsigned FIELD_W   = 8;

endpackage

// File: rtl/mcu_regfile.sv
module mcu_regfile #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [SEL_W-1:0] raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [SEL_W-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] regs [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
    import mcu_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  alu_op_t          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_PASS: y = a;
            default:  y = a;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
    import mcu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic [DATA_W-1:0]    rn_q,
    input  logic [DATA_W-1:0]    rm_q,
    input  logic [DATA_W-1:0]    alu_y,
    input  logic                 alu_zero,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 mem_re,
    output logic                 mem_we,
    output alu_op_t              alu_op,
    output logic                 rf_we,
    output logic [REG_SEL_W-1:0] rf_sel_n,
    output logic [REG_SEL_W-1:0] rf_sel_m,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_valid
);

    ctl_state_t         state, state_nx;
    logic [ADDR_W-1:0]  pc;
    logic [DATA_W-1:0]  ir;
    opc_t               opc;
    logic [ADDR_W-1:0]  dir_addr;
    logic [ADDR_W-1:0]  rel_ext;
    logic [DATA_W-1:0]  imm_ext;

    assign opc      = opc_t'(ir[DATA_W-1 -: 4]);
    assign rf_sel_n = ir[11:8];
    assign rf_sel_m = ir[7:4];
    assign dir_addr = {{(ADDR_W-FIELD_W){1'b0}}, ir[FIELD_W-1:0]};
    assign rel_ext  = {{(ADDR_W-FIELD_W){ir[FIELD_W-1]}}, ir[FIELD_W-1:0]};
    assign imm_ext  = {{(DATA_W-FIELD_W){1'b0}}, ir[FIELD_W-1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RESET;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = S_FETCH;
        unique case (state)
            S_RESET:  state_nx = S_FETCH;
            S_FETCH:  state_nx = S_FWAIT;
            S_FWAIT:  state_nx = S_DECODE;
            S_DECODE: begin
                unique case (opc)
                    OP_LDD:  state_nx = S_LDD;
                    OP_STD:  state_nx = S_STD;
                    OP_STI:  state_nx = S_STI;
                    OP_LDI:  state_nx = S_LDI;
                    OP_ADD:  state_nx = S_ADD;
                    OP_SUB:  state_nx = S_SUB;
                    OP_JZ:   state_nx = S_JZ;
                    OP_OUT:  state_nx = S_OUT;
                    default: state_nx = S_NOP;
                endcase
            end
            S_LDD:      state_nx = S_LDD_WAIT;
            S_OUT:      state_nx = S_OUT_WAIT;
            S_LDD_WAIT, S_STD, S_STI, S_LDI, S_ADD, S_SUB,
            S_JZ, S_OUT_WAIT, S_NOP: state_nx = S_FETCH;
            default:    state_nx = S_RESET;
        endcase
    end

    // program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            unique case (state)
                S_RESET: pc <= '0;
                S_FWAIT: begin
                    ir <= mem_rdata;
                    pc <= pc + ADDR_W'(1);
                end
                S_JZ: if (alu_zero) pc <= pc + rel_ext;
                default: ;
            endcase
        end
    end

    // per-state outputs
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        alu_op    = ALU_PASS;
        rf_we     = 1'b0;
        rf_wdata  = '0;
        out_data  = '0;
        out_valid = 1'b0;
        unique case (state)
            S_FETCH: begin
                mem_addr = pc;
                mem_re   = 1'b1;
            end
            S_LDD, S_OUT: begin
                mem_addr = dir_addr;
                mem_re   = 1'b1;
            end
            S_LDD_WAIT: begin
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
            end
            S_STD: begin
                mem_addr  = dir_addr;
                mem_wdata = rn_q;
                mem_we    = 1'b1;
            end
            S_STI: begin
                mem_addr  = ADDR_W'(rn_q);
                mem_wdata = rm_q;
                mem_we    = 1'b1;
            end
            S_LDI: begin
                rf_we    = 1'b1;
                rf_wdata = imm_ext;
            end
            S_ADD: begin
                alu_op   = ALU_ADD;
                rf_we    = 1'b1;
                rf_wdata = alu_y;
            end
            S_SUB: begin
                alu_op   = ALU_SUB;
                rf_we    = 1'b1;
                rf_wdata = alu_y;
            end
            S_JZ: alu_op = ALU_PASS;
            S_OUT_WAIT: begin
                out_data  = mem_rdata;
                out_valid = 1'b1;
            end
            default: ;
        endcase
    end

    a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FWAIT) |=> (pc == $past(pc) + ADDR_W'(1)));

    a_r1_fetch_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && $past(state) == S_RESET) |-> (mem_addr == '0));

    a_r8_jz_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_JZ && !alu_zero) |=> (pc == $past(pc)));

    a_r9_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r9_strobe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mem_re));

    a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NOP) |-> (!mem_we && !rf_we && !out_valid));

endmodule

// File: rtl/tiny_mcu_core.sv
module tiny_mcu_core
    import mcu_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned RF_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    logic [DATA_W-1:0]    rn_q, rm_q, alu_y, rf_wdata;
    logic                 alu_zero, rf_we;
    logic [REG_SEL_W-1:0] sel_n, sel_m;
    alu_op_t              alu_op;

    mcu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .rn_q      (rn_q),
        .rm_q      (rm_q),
        .alu_y     (alu_y),
        .alu_zero  (alu_zero),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .alu_op    (alu_op),
        .rf_we     (rf_we),
        .rf_sel_n  (sel_n),
        .rf_sel_m  (sel_m),
        .rf_wdata  (rf_wdata),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    mcu_regfile #(.WIDTH(DATA_W), .DEPTH(RF_DEPTH)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (sel_n),
        .wdata   (rf_wdata),
        .raddr_a (sel_n),
        .rdata_a (rn_q),
        .raddr_b (sel_m),
        .rdata_b (rm_q)
    );

    mcu_alu #(.WIDTH(DATA_W)) alu_i (
        .op   (alu_op),
        .a    (rn_q),
        .b    (rm_q),
        .y    (alu_y),
        .zero (alu_zero)
    );

endmodule

// File: tb/tiny_mcu_core_tb_top.sv
module tiny_mcu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, out_data;
    logic        mem_re, mem_we, out_valid;

    always #2 clk = ~clk;

    tiny_mcu_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // behavioural memory, one-cycle read latency
    logic [15:0] mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re)      mem_rdata <= mem[mem_addr[7:0]];
    end

    // output strobe capture
    logic [15:0] seen [32];
    int          seen_n = 0;
    logic        seen_clr = 1'b0;

    always @(negedge clk) begin
        if (seen_clr) seen_n <= 0;
        else if (rst_n && out_valid) begin
            if (seen_n < 32) seen[seen_n] <= out_data;
            seen_n <= seen_n + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] prog [256];
    logic [7:0]  pa [8];
    logic [7:0]  pb [8];

    function automatic logic [15:0] fib_at(input int k);
        logic [15:0] x = 16'd0, y = 16'd1, t;
        for (int i = 0; i < k; i++) begin
            t = x + y; x = y; y = t;
        end
        return x;
    endfunction

    function automatic logic [15:0] exp_sum(input logic [7:0] a, input logic [7:0] b);
        return 16'(a) + 16'(b);
    endfunction

    function automatic logic [15:0] exp_diff(input logic [7:0] a, input logic [7:0] b);
        return 16'(a) - 16'(b);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_and_reset();
        rst_n = 1'b0;
        seen_clr = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        seen_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_strobes(input int want, input int limit);
        int c = 0;
        while (seen_n < want && c < limit) begin
            @(negedge clk); c++;
        end
        if (seen_n < want) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog strobes actual=%0d expected=%0d", seen_n, want);
        end
    endtask

    initial begin
        // ---------------- phase 1: Fibonacci program ----------------
        for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
        prog[0]  = 16'h3000; prog[1]  = 16'h3101; prog[2]  = 16'h3232;
        prog[3]  = 16'h330A; prog[4]  = 16'h3401; prog[5]  = 16'h3600;
        prog[6]  = 16'h2200; // M[R2] = R0          (R5)
        prog[7]  = 16'h3500; prog[8]  = 16'h4500; prog[9]  = 16'h4510;
        prog[10] = 16'h3000; prog[11] = 16'h4010;
        prog[12] = 16'h3100; prog[13] = 16'h4150;
        prog[14] = 16'h4240; prog[15] = 16'h5340;
        prog[16] = 16'h6301; // exit when count is zero   (R8)
        prog[17] = 16'h66F4; // back to 6                (R8)
        for (int i = 0; i < 10; i++) prog[18+i] = 16'h7032 + 16'(i);
        prog[28] = 16'h073B; // R7 = M59             (R3)
        prog[29] = 16'h173C; // M60 = R7             (R4)
        prog[30] = 16'h8123; // no-op                (R10)
        prog[31] = 16'h703C; // out M60
        prog[32] = 16'h3903; prog[33] = 16'h3A05;
        prog[34] = 16'h59A0; // 3-5 wraps            (R7)
        prog[35] = 16'h193D;
        prog[36] = 16'h39FF; // imm 0xFF             (R6)
        prog[37] = 16'h193E;
        prog[38] = 16'h66FF; // halt loop

        load_and_reset();
        // R1: reset state at the ports
        chk("R1", "re in reset", {15'd0, mem_re}, 16'd0);
        chk("R1", "we in reset", {15'd0, mem_we}, 16'd0);
        chk("R1", "strobe in reset", {15'd0, out_valid}, 16'd0);
        rst_n = 1'b1;
        begin
            int c = 0;
            while (!mem_re && c < 10) begin @(negedge clk); c++; end
        end
        chk("R1", "first fetch addr", mem_addr, 16'h0000);
        chk("R2", "first fetch re", {15'd0, mem_re}, 16'd1);

        wait_strobes(11, 20000);
        repeat (60) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk("R5", $sformatf("fib mem[%0d]", 50+i), mem[50+i], fib_at(i));
            chk("R9", $sformatf("strobe %0d", i), seen[i], fib_at(i));
        end
        chk("R3", "copy via load/store", mem[60], 16'd34);
        chk("R9", "strobe after no-op", seen[10], 16'd34);
        chk("R10", "strobe count", 16'(seen_n), 16'd11);
        chk("R10", "no-op did not store", mem[35], 16'h193D);
        chk("R7", "wrapped difference", mem[61], 16'hFFFE);
        chk("R6", "zero-extended immediate", mem[62], 16'h00FF);

        // ---------------- phase 2: random and corner arithmetic ----------------
        void'($urandom(32'd20240611));
        pa[0] = 8'h00; pb[0] = 8'h00;
        pa[1] = 8'hFF; pb[1] = 8'hFF;
        pa[2] = 8'h00; pb[2] = 8'hFF;
        for (int i = 3; i < 8; i++) begin
            pa[i] = 8'($urandom_range(0, 255));
            pb[i] = 8'($urandom_range(0, 255));
        end
        for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
        for (int i = 0; i < 8; i++) begin
            prog[7*i+0] = {8'h31, pa[i]};
            prog[7*i+1] = {8'h32, pb[i]};
            prog[7*i+2] = {8'h33, pa[i]};
            prog[7*i+3] = 16'h4120;
            prog[7*i+4] = 16'h5320;
            prog[7*i+5] = {8'h11, 8'(8'h80 + 2*i)};
            prog[7*i+6] = {8'h13, 8'(8'h81 + 2*i)};
        end
        prog[56] = 16'h66FF;
        load_and_reset();
        rst_n = 1'b1;
        repeat (800) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            chk("R7", $sformatf("sum pair %0d", i), mem[8'h80 + 2*i], exp_sum(pa[i], pb[i]));
            chk("R7", $sformatf("diff pair %0d", i), mem[8'h81 + 2*i], exp_diff(pa[i], pb[i]));
        end
        chk("R4", "code untouched", mem[56], 16'h66FF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // global watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
            $finish;
        end
    end

endmodule